// File: doc/BRIEF.md
# Two-Rate Three-Color Ingress Policer

This block meters a stream of packet descriptors against two token buckets, a committed bucket and a peak bucket. It assigns each packet a color (green, yellow or red) and a pass or drop verdict. Each bucket has a refill amount and a depth. Both are given as a mantissa and an exponent, which together mean (1 + mantissa/256)·2^exponent tokens. A programmable timer drives the refill. Its period is a base tick count scaled by 2^rdiv. Token counts are held in fixed point with eight fractional bits, so the smallest cost a packet can have is 1/256 of a token.

A packet's cost in tokens comes from its length minus a programmable offset, plus an adjustment term that also uses the mantissa/exponent form. A length-mode bit drops the length term entirely. With that bit set and the adjustment chosen to equal one token, the block limits packets per second instead of bytes per second. A color-mode field picks between two modes. In color-blind operation the block ignores the color that arrives with the packet. In color-aware operation a packet that arrives yellow or red can only be marked the same color or a worse one.

Software programs six registers through a write-only port. A descriptor is accepted on a valid/ready handshake, and its verdict appears on the output two clock edges later.

Top module: `trtcm_policer`

## Requirements
- R1: Internal reset release happens on the second clock edge after rst_n rises. From then on, pkt_ready is high, dec_valid is low and both buckets are empty. The register defaults are:
  - all four bucket registers: exponent 24, mantissa 0;
  - cost adjustment: mantissa 256, exponent 0, length mode off;
  - length offset 0 and rdiv 0;
  - actions: green pass, yellow pass, red drop;
  - color mode 3 (blind).
  So the first packet after reset is red and dropped.
- R2: A cycle with cfg_we high writes the 20-bit cfg_wdata into the register at cfg_addr. Addresses 0 to 3 hold the committed refill, committed depth, peak refill and peak depth. In each of these, bits 7:0 are the mantissa and bits 12:8 the exponent. The value in 1/256-token units is (256+mantissa)·2^exponent, and any exponent of 24 or more gives zero. Writes to addresses 6 and 7 change nothing.
- R3: A refill event occurs every TICK_CYC·2^rdiv cycles, where rdiv is register 5 bits 11:8. At each event a bucket gains its refill value. A bucket level never exceeds its depth: after a depth is lowered, the level is clamped at the next edge.
- R4: Register 4 holds the cost adjustment:
  - bits 8:0: adjustment mantissa;
  - bits 13:9: adjustment exponent (values above 23 act as 23);
  - bit 14: length mode.
  Register 5 bits 7:0 hold the length offset. The cost in 1/256-token units is max((length mode ? 0 : (length − offset)·256) + (mantissa − 256)·2^exponent, 1).
- R5: With length mode 1, adjustment mantissa 384 and exponent 1, every packet costs exactly one token (256 units), whatever its length.
- R6: In blind mode a packet is red if the committed level is below its cost. Otherwise it is yellow if the peak bucket is in use (depth not zero) and the peak level is below the cost. Otherwise it is green. Colors are encoded 0 green, 1 yellow, 2 red.
- R7: A green packet debits its cost from the committed bucket, and also from the peak bucket if that bucket is in use. A yellow packet debits the committed bucket only. A red packet debits nothing. The next packet sees the debits of the packet before it, even when the two are back to back.
- R8: In blind mode with a peak depth of zero, no packet is ever marked yellow.
- R9: The color mode is register 5 bits 19:18, and pkt_color uses the color encoding of R6 (3 counts as red).
  - Mode 3 is blind and ignores pkt_color.
  - In any other mode, a packet arriving red is red and debits nothing.
  - A packet arriving yellow is red if the committed bucket lacks its cost, and yellow otherwise.
- R10: The action codes sit in register 5: green in bits 13:12, yellow in bits 15:14 and red in bits 17:16. For the packet's final color, code 01 sets dec_drop, and any other code passes the packet.
- R11: A descriptor is accepted at an edge where pkt_valid and pkt_ready are both high. pkt_ready is low in every cycle in which cfg_we is high. A descriptor accepted at edge n raises dec_valid for exactly the cycle after edge n+1, together with its color and verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 20 | Register write data |
| pkt_valid | input | 1 | Descriptor present |
| pkt_ready | output | 1 | Descriptor can be taken this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_color | input | 2 | Color arriving with the packet |
| dec_valid | output | 1 | Verdict present |
| dec_color | output | 2 | Assigned color |
| dec_drop | output | 1 | Packet is to be dropped |

## Verification
The bench runs several kinds of traffic, and each one isolates a different mistake.
- Back-to-back packets-per-second traffic against a drained bucket with no refill shows whether the per-packet cost is exactly one token, whether the depth cap holds, and whether each debit reaches the following packet.
- Packets shorter than the offset show whether the 1/256 floor on the cost applies.
- A shallow peak bucket with no refill shows whether a yellow verdict wrongly debits the peak bucket.
- Pre-colored packets in aware mode show whether incoming red and yellow are honored.
- Randomized profiles and traffic, with rdiv, offsets and actions all varying, are compared cycle by cycle against a model in the bench. This catches errors in refill timing, rounding and action mapping that the directed cases miss.

// File: rtl/trtcm_pkg.sv
package trtcm_pkg;
  localparam int EXP_W     = 5;
  localparam int MANT_W    = 8;
  localparam int ADJM_W    = 9;
  localparam int OFS_W     = 8;
  localparam int RDIV_W    = 4;
  localparam int CFG_W     = 20;
  localparam int ADDR_W    = 3;
  localparam int EXP_OFF   = 24;
  localparam int EXP_CLAMP = 23;
  localparam int FRAC_W    = 8;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } color_e;

  localparam logic [1:0] ACT_DROP    = 2'b01;
  localparam logic [1:0] CMODE_BLIND = 2'b11;

  localparam logic [ADDR_W-1:0] A_CRATE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CDEPTH = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRATE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PDEPTH = 3'd3;
  localparam logic [ADDR_W-1:0] A_COST   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;

  typedef struct packed {
    logic [EXP_W-1:0]  e;
    logic [MANT_W-1:0] m;
  } fmt_t;
endpackage

// File: rtl/trtcm_rst_sync.sv
module trtcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/trtcm_expand.sv
module trtcm_expand
  import trtcm_pkg::*;
#(
  parameter int TOK_W = 34
) (
  input  fmt_t             fmt,
  output logic [TOK_W-1:0] val
);
  logic [TOK_W-1:0] base;

  always_comb begin
    base = TOK_W'({1'b1, fmt.m});
    if (fmt.e >= EXP_W'(EXP_OFF)) val = '0;
    else                          val = base << fmt.e;
  end
endmodule

// File: rtl/trtcm_cost.sv
module trtcm_cost
  import trtcm_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TOK_W = 34
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [ADJM_W-1:0] adj_m,
  input  logic [EXP_W-1:0]  adj_e,
  input  logic              len_off,
  output logic [TOK_W-1:0]  cost
);
  localparam int SW = TOK_W + 2;

  logic signed [SW-1:0] len_s, ofs_s, m_s, base_s, adj_s, sum_s;
  logic [EXP_W-1:0]     e_c;

  always_comb begin
    e_c    = (adj_e > EXP_W'(EXP_CLAMP)) ? EXP_W'(EXP_CLAMP) : adj_e;
    len_s  = $signed({{(SW-LEN_W){1'b0}}, len});
    ofs_s  = $signed({{(SW-OFS_W){1'b0}}, ofs});
    m_s    = $signed({{(SW-ADJM_W){1'b0}}, adj_m});
    base_s = len_off ? '0 : ((len_s - ofs_s) <<< FRAC_W);
    adj_s  = (m_s - $signed(SW'(256))) <<< e_c;
    sum_s  = base_s + adj_s;
    if (sum_s < $signed(SW'(1))) cost = TOK_W'(1);
    else                         cost = sum_s[TOK_W-1:0];
  end
endmodule

// File: rtl/trtcm_timer.sv
module trtcm_timer
  import trtcm_pkg::*;
#(
  parameter int TICK_CYC = 500
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [RDIV_W-1:0] rdiv,
  output logic              tick
);
  localparam longint MAXP  = longint'(TICK_CYC) << ((1 << RDIV_W) - 1);
  localparam int     CNT_W = $clog2(MAXP + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, period;

  always_comb begin
    period = CNT_W'(TICK_CYC) << rdiv;
    tick   = (cnt_q >= period - CNT_W'(1));
    cnt_d  = tick ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trtcm_bucket.sv
module trtcm_bucket #(
  parameter int TOK_W = 34
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             tick,
  input  logic [TOK_W-1:0] rate,
  input  logic [TOK_W-1:0] depth,
  input  logic             debit_en,
  input  logic [TOK_W-1:0] debit_amt,
  output logic [TOK_W-1:0] level
);
  logic [TOK_W-1:0] lvl_q, lvl_d;
  logic [TOK_W:0]   after, sum;

  always_comb begin
    after = {1'b0, lvl_q} - (debit_en ? {1'b0, debit_amt} : '0);
    sum   = tick ? (after + {1'b0, rate}) : after;
    lvl_d = (sum > {1'b0, depth}) ? depth : sum[TOK_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer
  import trtcm_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int TOK_W    = 34,
  parameter int TICK_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [19:0]       cfg_wdata,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [1:0]        pkt_color,
  output logic              dec_valid,
  output logic [1:0]        dec_color,
  output logic              dec_drop
);
  localparam int NB = 2;       // committed = 0, peak = 1
  localparam int NF = 2 * NB;  // rate/depth per bucket

  logic srst_n;
  trtcm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // configuration registers
  fmt_t              fmt_q [NF];
  fmt_t              fmt_d [NF];
  logic [ADJM_W-1:0] adjm_q, adjm_d;
  logic [EXP_W-1:0]  adje_q, adje_d;
  logic              loff_q, loff_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [RDIV_W-1:0] rdiv_q, rdiv_d;
  logic [1:0]        act_q [3];
  logic [1:0]        act_d [3];
  logic [1:0]        cmode_q, cmode_d;

  always_comb begin
    for (int i = 0; i < NF; i++) fmt_d[i] = fmt_q[i];
    for (int c = 0; c < 3; c++)  act_d[c] = act_q[c];
    adjm_d  = adjm_q;
    adje_d  = adje_q;
    loff_d  = loff_q;
    ofs_d   = ofs_q;
    rdiv_d  = rdiv_q;
    cmode_d = cmode_q;
    if (cfg_we) begin
      case (cfg_addr)
        A_CRATE, A_CDEPTH, A_PRATE, A_PDEPTH: begin
          fmt_d[cfg_addr[1:0]].m = cfg_wdata[7:0];
          fmt_d[cfg_addr[1:0]].e = cfg_wdata[12:8];
        end
        A_COST: begin
          adjm_d = cfg_wdata[8:0];
          adje_d = cfg_wdata[13:9];
          loff_d = cfg_wdata[14];
        end
        A_CTRL: begin
          ofs_d    = cfg_wdata[7:0];
          rdiv_d   = cfg_wdata[11:8];
          act_d[0] = cfg_wdata[13:12];
          act_d[1] = cfg_wdata[15:14];
          act_d[2] = cfg_wdata[17:16];
          cmode_d  = cfg_wdata[19:18];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < NF; i++) begin
        fmt_q[i].m <= '0;
        fmt_q[i].e <= EXP_W'(EXP_OFF);
      end
      adjm_q   <= ADJM_W'(256);
      adje_q   <= '0;
      loff_q   <= 1'b0;
      ofs_q    <= '0;
      rdiv_q   <= '0;
      act_q[0] <= 2'b00;
      act_q[1] <= 2'b00;
      act_q[2] <= ACT_DROP;
      cmode_q  <= CMODE_BLIND;
    end else begin
      for (int i = 0; i < NF; i++) fmt_q[i] <= fmt_d[i];
      for (int c = 0; c < 3; c++)  act_q[c] <= act_d[c];
      adjm_q  <= adjm_d;
      adje_q  <= adje_d;
      loff_q  <= loff_d;
      ofs_q   <= ofs_d;
      rdiv_q  <= rdiv_d;
      cmode_q <= cmode_d;
    end
  end

  // decoded values
  logic [TOK_W-1:0] fval [NF];
  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_exp
      trtcm_expand #(.TOK_W(TOK_W)) u_exp (.fmt(fmt_q[gi]), .val(fval[gi]));
    end
  endgenerate

  // refill timer
  logic tick;
  trtcm_timer #(.TICK_CYC(TICK_CYC)) u_tmr (
    .clk(clk), .srst_n(srst_n), .rdiv(rdiv_q), .tick(tick)
  );

  // stage 1: accept and cost
  logic             accept;
  logic [TOK_W-1:0] cost_c;
  logic             s1_v_q, s1_v_d;
  logic [TOK_W-1:0] s1_cost_q, s1_cost_d;
  logic [1:0]       s1_col_q, s1_col_d;

  assign pkt_ready = srst_n & ~cfg_we;
  assign accept    = pkt_valid & pkt_ready;

  trtcm_cost #(.LEN_W(LEN_W), .TOK_W(TOK_W)) u_cost (
    .len(pkt_len), .ofs(ofs_q), .adj_m(adjm_q), .adj_e(adje_q),
    .len_off(loff_q), .cost(cost_c)
  );

  always_comb begin
    s1_v_d    = accept;
    s1_cost_d = accept ? cost_c : s1_cost_q;
    s1_col_d  = accept ? pkt_color : s1_col_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_v_q    <= 1'b0;
      s1_cost_q <= '0;
      s1_col_q  <= '0;
    end else begin
      s1_v_q    <= s1_v_d;
      s1_cost_q <= s1_cost_d;
      s1_col_q  <= s1_col_d;
    end
  end

  // stage 2: buckets and marking
  logic [TOK_W-1:0] lvl [NB];
  logic             deb [NB];

  generate
    for (gi = 0; gi < NB; gi++) begin : g_bkt
      trtcm_bucket #(.TOK_W(TOK_W)) u_bkt (
        .clk(clk), .srst_n(srst_n), .tick(tick),
        .rate(fval[2*gi]), .depth(fval[2*gi+1]),
        .debit_en(deb[gi]), .debit_amt(s1_cost_q), .level(lvl[gi])
      );
    end
  endgenerate

  logic   blind, in_red, in_yel, c_ok, p_used, p_ok;
  color_e col_c;
  logic   drop_c;

  always_comb begin
    blind  = (cmode_q == CMODE_BLIND);
    in_red = !blind && s1_col_q[1];
    in_yel = !blind && (s1_col_q == 2'd1);
    c_ok   = (lvl[0] >= s1_cost_q);
    p_used = (fval[3] != '0);
    p_ok   = !p_used || (lvl[1] >= s1_cost_q);
    if (in_red || !c_ok)      col_c = COL_RED;
    else if (in_yel || !p_ok) col_c = COL_YELLOW;
    else                      col_c = COL_GREEN;
    deb[0] = s1_v_q && (col_c != COL_RED);
    deb[1] = s1_v_q && (col_c == COL_GREEN) && p_used;
    drop_c = (act_q[col_c] == ACT_DROP);
  end

  logic       dv_q;
  logic [1:0] dc_q;
  logic       dd_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dv_q <= 1'b0;
      dc_q <= '0;
      dd_q <= 1'b0;
    end else begin
      dv_q <= s1_v_q;
      if (s1_v_q) begin
        dc_q <= col_c;
        dd_q <= drop_c;
      end
    end
  end

  assign dec_valid = dv_q;
  assign dec_color = dc_q;
  assign dec_drop  = dd_q;

  // observation points for the checker
  logic [TOK_W-1:0] c_lvl, p_lvl, c_depth, p_depth;
  assign c_lvl   = lvl[0];
  assign p_lvl   = lvl[1];
  assign c_depth = fval[1];
  assign p_depth = fval[3];
endmodule

// File: rtl/trtcm_policer_chk.sv
module trtcm_policer_chk #(
  parameter int TOK_W = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic             dec_valid,
  input logic [1:0]       dec_color,
  input logic             dec_drop,
  input logic [TOK_W-1:0] c_lvl,
  input logic [TOK_W-1:0] p_lvl,
  input logic [TOK_W-1:0] c_depth,
  input logic [TOK_W-1:0] p_depth,
  input logic [1:0]       cmode,
  input logic [1:0]       act_g,
  input logic [1:0]       act_r
);
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  assert_accept_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && pkt_valid && pkt_ready) |=> ##1 dec_valid);

  assert_idle_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && !(pkt_valid && pkt_ready)) |=> ##1 !dec_valid);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1) |-> (c_lvl <= $past(c_depth)));

  assert_peak_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1) |-> (p_lvl <= $past(p_depth)));

  assert_color_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_color != 2'b11));

  assert_no_yellow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1 && dec_valid && $past(p_depth) == '0 && $past(cmode) == 2'b11)
      |-> (dec_color != 2'd1));

  assert_red_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1 && dec_valid && dec_color == 2'd2) |-> (dec_drop == ($past(act_r) == 2'b01)));

  assert_green_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1 && dec_valid && dec_color == 2'd0) |-> (dec_drop == ($past(act_g) == 2'b01)));
endmodule

bind trtcm_policer trtcm_policer_chk #(.TOK_W(TOK_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .dec_valid(dec_valid), .dec_color(dec_color), .dec_drop(dec_drop),
  .c_lvl(c_lvl), .p_lvl(p_lvl), .c_depth(c_depth), .p_depth(p_depth),
  .cmode(cmode_q), .act_g(act_q[0]), .act_r(act_q[2])
);

// File: tb/test_trtcm_policer.sv
module test_trtcm_policer;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int TOK_W = 34;
  localparam int TICK  = 4;

  logic clk, rst_n, cfg_we, pkt_valid, pkt_ready, dec_valid, dec_drop;
  logic [2:0] cfg_addr;
  logic [19:0] cfg_wdata;
  logic [LEN_W-1:0] pkt_len;
  logic [1:0] pkt_color, dec_color;

  trtcm_policer #(.LEN_W(LEN_W), .TOK_W(TOK_W), .TICK_CYC(TICK)) i_trtcm_policer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_len(pkt_len), .pkt_color(pkt_color),
    .dec_valid(dec_valid), .dec_color(dec_color), .dec_drop(dec_drop)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic longint f_exp(int m, int e);
    if (e >= 24) return 0;
    return longint'(256 + m) << e;
  endfunction

  function automatic longint f_cost(int len, int ofs, int m, int e, int lm);
    int ec;
    longint s;
    ec = (e > 23) ? 23 : e;
    s = (lm != 0) ? 0 : longint'(len - ofs) * 256;
    s = s + longint'(m - 256) * (longint'(1) << ec);
    if (s < 1) s = 1;
    return s;
  endfunction

  int bm[4], be[4], am, ae, lm, ofs, rdv, act[3], cmode;
  longint clv, plv, s1c, tcnt;
  bit s1v; int s1col;
  bit [1:0] m_rs;
  bit exp_v; int exp_col; bit exp_drop;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin bm[i] = 0; be[i] = 24; end
    am = 256; ae = 0; lm = 0; ofs = 0; rdv = 0;
    act[0] = 0; act[1] = 0; act[2] = 1; cmode = 3;
    clv = 0; plv = 0; s1v = 0; s1c = 0; s1col = 0; tcnt = 0; exp_v = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 2'b00;
      model_reset();
    end else begin
      if (m_rs[1]) begin
        longint cd, pd, cr, pr;
        bit tk, pused;
        int col;
        cr = f_exp(bm[0], be[0]); cd = f_exp(bm[1], be[1]);
        pr = f_exp(bm[2], be[2]); pd = f_exp(bm[3], be[3]);
        pused = (pd != 0);
        exp_v = s1v;
        if (s1v) begin
          bit blind;
          blind = (cmode == 3);
          if ((!blind && s1col >= 2) || clv < s1c) col = 2;
          else if ((!blind && s1col == 1) || (pused && plv < s1c)) col = 1;
          else col = 0;
          exp_col = col;
          exp_drop = (act[col] == 1);
          if (col != 2) clv = clv - s1c;
          if (col == 0 && pused) plv = plv - s1c;
        end
        tk = (tcnt >= (longint'(TICK) << rdv) - 1);
        tcnt = tk ? 0 : tcnt + 1;
        if (tk) begin clv = clv + cr; plv = plv + pr; end
        if (clv > cd) clv = cd;
        if (plv > pd) plv = pd;
        if (pkt_valid && !cfg_we) begin
          s1v = 1; s1c = f_cost(int'(pkt_len), ofs, am, ae, lm); s1col = int'(pkt_color);
        end else s1v = 0;
        if (cfg_we) begin
          case (cfg_addr)
            3'd0, 3'd1, 3'd2, 3'd3: begin
              bm[cfg_addr[1:0]] = int'(cfg_wdata[7:0]);
              be[cfg_addr[1:0]] = int'(cfg_wdata[12:8]);
            end
            3'd4: begin am = int'(cfg_wdata[8:0]); ae = int'(cfg_wdata[13:9]); lm = int'(cfg_wdata[14]); end
            3'd5: begin
              ofs = int'(cfg_wdata[7:0]); rdv = int'(cfg_wdata[11:8]);
              act[0] = int'(cfg_wdata[13:12]); act[1] = int'(cfg_wdata[15:14]);
              act[2] = int'(cfg_wdata[17:16]); cmode = int'(cfg_wdata[19:18]);
            end
            default: ;
          endcase
        end
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  // ---------------- monitor ----------------
  int log_col[16]; bit log_drop[16]; int log_n = 0;

  always @(negedge clk) begin
    if (rst_n && m_rs[1] && !done && (dec_valid || exp_v)) begin
      chk(dec_valid == exp_v, tag, "dec_valid", longint'(dec_valid), longint'(exp_v));
      if (dec_valid && exp_v) begin
        chk(int'(dec_color) == exp_col, tag, "dec_color", longint'(dec_color), longint'(exp_col));
        chk(dec_drop == exp_drop, tag, "dec_drop", longint'(dec_drop), longint'(exp_drop));
      end
      if (dec_valid && log_n < 16) begin
        log_col[log_n] = int'(dec_color); log_drop[log_n] = dec_drop; log_n++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg_write(logic [2:0] a, logic [19:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    #1;
    chk(pkt_ready == 1'b0, "R11", "pkt_ready during write", longint'(pkt_ready), 0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [19:0] fmt(int m, int e);
    return 20'((e << 8) | m);
  endfunction

  function automatic logic [19:0] ctrl(int o, int rd, int ag, int ay, int ar, int cm);
    return 20'(o | (rd << 8) | (ag << 12) | (ay << 14) | (ar << 16) | (cm << 18));
  endfunction

  task automatic send(int len, int col);
    pkt_valid = 1'b1; pkt_len = LEN_W'(len); pkt_color = 2'(col);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_log(string req, int idx, int col, bit drp);
    chk(log_n > idx, req, "decision count", longint'(log_n), longint'(idx + 1));
    if (log_n > idx) begin
      chk(log_col[idx] == col, req, "logged color", longint'(log_col[idx]), longint'(col));
      chk(log_drop[idx] == drp, req, "logged drop", longint'(log_drop[idx]), longint'(drp));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd12345);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pkt_valid = 1'b0; pkt_len = '0; pkt_color = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and default profile
    tag = "R1";
    chk(dec_valid == 1'b0, "R1", "dec_valid after reset", longint'(dec_valid), 0);
    chk(pkt_ready == 1'b1, "R1", "pkt_ready after reset", longint'(pkt_ready), 1);
    log_n = 0;
    send(64, 0);
    drain();
    expect_log("R1", 0, 2, 1'b1);

    // R5, R3, R7: packet-rate mode, depth of three tokens, back to back
    tag = "R5";
    cfg_write(3'd5, ctrl(0, 0, 0, 0, 1, 3));
    cfg_write(3'd1, fmt(128, 1));
    cfg_write(3'd0, fmt(0, 8));
    cfg_write(3'd4, 20'(384 | (1 << 9) | (1 << 14)));
    repeat (12) @(negedge clk);
    cfg_write(3'd0, fmt(0, 24));
    repeat (2) @(negedge clk);
    log_n = 0;
    for (int i = 0; i < 5; i++) send(100 + 300 * i, 0);
    drain();
    expect_log("R5", 0, 0, 1'b0);
    expect_log("R7", 1, 0, 1'b0);
    expect_log("R3", 2, 0, 1'b0);
    expect_log("R3", 3, 2, 1'b1);
    expect_log("R7", 4, 2, 1'b1);

    // R4: cost floor of 1/256 when length is below offset
    tag = "R4";
    cfg_write(3'd4, 20'(256));
    cfg_write(3'd5, ctrl(100, 0, 0, 0, 1, 3));
    cfg_write(3'd1, fmt(0, 0));
    cfg_write(3'd0, fmt(0, 8));
    repeat (10) @(negedge clk);
    cfg_write(3'd0, fmt(0, 24));
    repeat (2) @(negedge clk);
    log_n = 0;
    send(10, 0); send(0, 0); send(50, 0); send(101, 0);
    drain();
    expect_log("R4", 0, 0, 1'b0);
    expect_log("R4", 1, 0, 1'b0);
    expect_log("R4", 2, 0, 1'b0);
    expect_log("R4", 3, 2, 1'b1);

    // R9, R10: color-aware mode with custom actions
    tag = "R9";
    cfg_write(3'd1, fmt(0, 16));
    cfg_write(3'd0, fmt(0, 12));
    cfg_write(3'd3, fmt(0, 16));
    cfg_write(3'd2, fmt(0, 12));
    cfg_write(3'd5, ctrl(0, 0, 0, 1, 0, 0));
    repeat (80) @(negedge clk);
    log_n = 0;
    send(64, 2); send(64, 1); send(64, 0); send(64, 3);
    drain();
    expect_log("R9", 0, 2, 1'b0);
    expect_log("R10", 1, 1, 1'b1);
    expect_log("R9", 2, 0, 1'b0);
    expect_log("R9", 3, 2, 1'b0);

    // R6, R7: shallow peak bucket, yellow leaves peak untouched
    tag = "R6";
    cfg_write(3'd2, fmt(0, 24));
    cfg_write(3'd3, fmt(0, 6));
    cfg_write(3'd5, ctrl(0, 0, 0, 0, 1, 3));
    repeat (3) @(negedge clk);
    log_n = 0;
    send(40, 0); send(40, 0); send(20, 0);
    drain();
    expect_log("R6", 0, 0, 1'b0);
    expect_log("R6", 1, 1, 1'b0);
    expect_log("R7", 2, 0, 1'b0);

    // R2, R8: committed bucket disabled, peak disabled; writes to 6/7 ignored
    tag = "R2";
    cfg_write(3'd3, fmt(0, 24));
    cfg_write(3'd6, 20'hFFFFF);
    cfg_write(3'd7, 20'hFFFFF);
    repeat (2) @(negedge clk);
    log_n = 0;
    send(1, 0);
    drain();
    expect_log("R8", 0, 0, 1'b0);
    cfg_write(3'd1, fmt(200, 25));
    repeat (2) @(negedge clk);
    log_n = 0;
    send(1, 0);
    drain();
    expect_log("R2", 0, 2, 1'b1);

    // randomized profiles and traffic against the model
    for (int r = 0; r < 10; r++) begin
      tag = (r % 2 == 0) ? "R6" : "R3";
      cfg_write(3'd0, fmt($urandom_range(0, 255), $urandom_range(4, 14)));
      cfg_write(3'd1, fmt($urandom_range(0, 255), ($urandom_range(0, 5) == 0) ? 24 : $urandom_range(6, 18)));
      cfg_write(3'd2, fmt($urandom_range(0, 255), $urandom_range(4, 15)));
      cfg_write(3'd3, fmt($urandom_range(0, 255), ($urandom_range(0, 3) == 0) ? 24 : $urandom_range(6, 19)));
      cfg_write(3'd4, 20'($urandom_range(0, 511) | ($urandom_range(0, 6) << 9) | ($urandom_range(0, 1) << 14)));
      cfg_write(3'd5, ctrl($urandom_range(0, 63), $urandom_range(0, 2), $urandom_range(0, 3),
                           $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)));
      for (int k = 0; k < 40; k++) begin
        send($urandom_range(0, 1500), $urandom_range(0, 3));
        repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      drain();
    end

    finish_run();
  end
endmodule